// File: doc/BRIEF.md
# Programmable Priority Bus Arbiter

This block decides which of several bus masters may use one shared slave port of an on-chip interconnect. Each master raises a request line and watches its own bit of a registered, one-hot grant vector. When the port is idle and only one master is asking, that master gets the grant on the next clock edge. When two or more are asking in the same cycle, the master with the highest programmed priority wins. If the top priorities are equal, the master with the smallest index wins.

Priorities live in a software-writable register with one 2-bit field per master. The value 3 is the most urgent and 0 the least. Once a master holds the grant, it keeps it whatever the request lines do, until the single transfer-done input is raised. The port then spends one idle cycle, and the next decision is taken from the requests and priorities present in that cycle. A priority write that lands while a grant is held changes nothing until that next decision.

Top module: `arb_prio`

## Requirements
- R1: After reset the grant vector is all zero and every priority field is 0, so four simultaneous requests are won by master 0.
- R2: The grant vector has at most one bit set in every cycle.
- R3: While no grant is held, a single requesting master is granted on the next clock edge.
- R4: While no grant is held and several masters request, the next edge grants the requester with the numerically largest priority field (3 highest, 0 lowest).
- R5: Among requesters that share the largest priority value, the lowest master index is granted.
- R6: A write with cfg_we high loads all of cfg_wdata into the priority register; the field of master i is bits [2i+1:2i].
- R7: A held grant stays unchanged on every edge at which done is low, whatever the request lines show.
- R8: An edge at which done is high while a grant is held clears the grant; a new grant can appear no earlier than the following edge.
- R9: A priority write made while a grant is held has no effect on that grant and is used at the next arbitration decision.
- R10: With no grant held, done has no effect, and with no requests the grant stays all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_MST (4) | Request line per master |
| done | input | 1 | The granted master's transfer has completed |
| cfg_we | input | 1 | Write strobe for the priority register |
| cfg_wdata | input | 2*N_MST (8) | New priority register value, 2 bits per master |
| grant | output | N_MST (4) | One-hot grant, all zero when the port is idle |

## Verification
The checker watches the cycle-level rules on every cycle: the grant is never more than one-hot, a held grant does not move while done is low, done releases it on the next edge, an idle port with no requests stays idle, and an idle port with requests grants one of the masters that asked. Which master is right depends on the programmed priorities and the tie-break rule. Only the bench's scenarios can show this. They use distinct priority settings, equal-priority ties at zero and nonzero levels, field placement checks, and a priority rewrite made under an active grant.

// File: rtl/arb_prio.sv
module arb_prio #(
  parameter int N_MST = 4,
  parameter int PW    = 2,
  localparam int CW   = N_MST * PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] req,
  input  logic             done,
  input  logic             cfg_we,
  input  logic [CW-1:0]    cfg_wdata,
  output logic [N_MST-1:0] grant
);

  logic [CW-1:0]    prio_q;
  logic [N_MST-1:0] grant_q;
  logic [N_MST-1:0] pick;
  logic [PW-1:0]    best_p;
  logic             found;
  logic             busy;

  assign busy  = |grant_q;
  assign grant = grant_q;

  always_comb begin
    pick   = '0;
    best_p = '0;
    found  = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      if (req[i] && (!found || prio_q[i*PW +: PW] > best_p)) begin
        pick    = '0;
        pick[i] = 1'b1;
        best_p  = prio_q[i*PW +: PW];
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prio_q <= '0;
    else if (cfg_we) prio_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    grant_q <= '0;
    else if (busy) grant_q <= done ? '0 : grant_q;
    else           grant_q <= pick;
  end

endmodule

// File: rtl/arb_prio_chk.sv
module arb_prio_chk #(
  parameter int N_MST = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] req,
  input logic             done,
  input logic [N_MST-1:0] grant
);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req != '0) |=> ($countones(grant) == 1 && (grant & $past(req)) != '0)); // R3

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !done) |=> (grant == $past(grant))); // R7

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && done) |=> (grant == '0)); // R8

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req == '0) |=> (grant == '0)); // R10

endmodule

bind arb_prio arb_prio_chk #(.N_MST(N_MST)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .req  (req),
  .done (done),
  .grant(grant)
);

// File: tb/sim_arb_prio.sv
module sim_arb_prio;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       done = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] grant;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  arb_prio u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .grant(grant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: inputs set after a falling edge, expected grant pushed after the rising edge
  task automatic step(input logic [3:0] r, input logic d, input logic we,
                      input logic [7:0] wd, input logic [3:0] exp, input string tag);
    req = r; done = d; cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    #1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      check({3'b0, ($countones(grant) > 1)}, 4'b0, "R2 one-hot");
      if (exp_q.size() > 0) check(grant, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(grant, 4'b0000, "R1 grant zero in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(grant, 4'b0000, "R1 grant zero after reset");

    step(4'b1111, 0, 0, 8'h00, 4'b0001, "R1 reset priorities equal -> m0");
    step(4'b0000, 1, 0, 8'h00, 4'b0000, "R8 done releases");

    for (int m = 0; m < 4; m++) begin
      step(4'b0001 << m, 0, 0, 8'h00, 4'b0001 << m, "R3 lone requester");
      step(4'b0000, 0, 0, 8'h00, 4'b0001 << m, "R7 hold with req low");
      step(4'b1111 ^ (4'b0001 << m), 0, 0, 8'h00, 4'b0001 << m, "R7 hold against others");
      step(4'b1111, 1, 0, 8'h00, 4'b0000, "R8 release on done");
      step(4'b0000, 0, 0, 8'h00, 4'b0000, "R10 idle no request");
    end

    // R6 field layout: m3=3 m2=0 m1=2 m0=1
    step(4'b0000, 0, 1, 8'b11_00_10_01, 4'b0000, "R10 write while idle, no request");
    step(4'b0000, 1, 0, 8'h00, 4'b0000, "R10 done while idle ignored");
    step(4'b1111, 0, 0, 8'h00, 4'b1000, "R4 highest priority m3");
    step(4'b1111, 0, 1, 8'b01_01_01_01, 4'b1000, "R9 write under grant keeps holder");
    step(4'b0111, 1, 0, 8'h00, 4'b0000, "R8 release");
    step(4'b0111, 0, 0, 8'h00, 4'b0001, "R9 new equal priorities used -> m0");
    step(4'b0000, 1, 0, 8'h00, 4'b0000, "R8 release");

    step(4'b0000, 0, 1, 8'b00_11_00_00, 4'b0000, "R6 write m2 field only");
    step(4'b0110, 0, 0, 8'h00, 4'b0100, "R6 m2 field bits [5:4]");
    step(4'b0110, 1, 0, 8'h00, 4'b0000, "R8 release");
    step(4'b1011, 0, 0, 8'h00, 4'b0001, "R4 all zero priorities -> m0");
    step(4'b0000, 1, 0, 8'h00, 4'b0000, "R8 release");

    step(4'b0000, 0, 1, 8'b10_00_10_00, 4'b0000, "R6 write m1=m3=2");
    step(4'b1010, 0, 0, 8'h00, 4'b0010, "R5 tie at 2 -> m1");
    step(4'b0000, 1, 0, 8'h00, 4'b0000, "R8 release");
    step(4'b1001, 0, 0, 8'h00, 4'b1000, "R4 m3 over m0");
    step(4'b1001, 1, 0, 8'h00, 4'b0000, "R8 release");
    step(4'b0101, 0, 0, 8'h00, 4'b0001, "R5 tie at 0 -> m0");
    step(4'b0000, 1, 0, 8'h00, 4'b0000, "R8 release");

    step(4'b0000, 0, 1, 8'b01_10_11_00, 4'b0000, "R6 write m1=3 m2=2 m3=1");
    step(4'b1101, 0, 0, 8'h00, 4'b0100, "R4 m2 highest of requesters");
    step(4'b0000, 1, 0, 8'h00, 4'b0000, "R8 release");

    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule